// File: doc/BRIEF.md
# One-Wire Slave ROM Command Layer

This block is the network layer of one slave on a shared one-wire bus. A bit-slot layer below it turns line activity into single-cycle strobes: a bus reset was seen, a bit was written by the master (with its value), or the master has opened a read slot. This block answers each read slot with the level to put on the line (0 pulls low, 1 releases). It decides whether the memory-function layer above may be used by raising a grant flag.

After a bus reset the block collects one 8-bit command. It can send its 64-bit identity, compare an identity sent by the master against its own, or skip addressing altogether. It can also take part in the bus-wide elimination search, in plain form or qualified by an alarm input from the sensor logic. The alarm input is high while the last measurement lay outside the trigger window. In the search, each identity bit costs three slots: the slave sends the bit, then sends its complement, then reads the master's chosen bit. On the wired-AND line, the master sees whether all remaining slaves agree. A slave whose bit differs from the master's choice drops out until the next reset.

Top module: `owire_rom_layer`

## Requirements
- R1: After `rst_n` is released the block is dormant: `tx_bit` is 1, `func_grant` is 0, and written bits and read slots are ignored until the first `bus_reset_stb`.
- R2: `bus_reset_stb` in any state clears `func_grant` in the next cycle and restarts command collection. A bit strobe or read strobe in the same cycle is discarded.
- R3: The command is the next 8 written bits, least significant first. 0x33 selects identity readout, 0x55 identity compare, 0xCC skip, 0xF0 search and 0xEC alarm search.
- R4: After 0x33, the next 64 read slots return `rom_id` bit 0 first, up to bit 63. Bits 7:0 are the family code, 55:8 the serial number and 63:56 the check byte. `func_grant` rises in the cycle after the 64th slot.
- R5: After 0x55, the next 64 written bits are compared with `rom_id`, bit 0 first. If all 64 agree, `func_grant` rises in the cycle after the 64th bit.
- R6: In identity compare, the first disagreeing bit makes the block dormant until the next bus reset. `func_grant` stays 0 and `tx_bit` stays 1.
- R7: After 0xCC, `func_grant` rises in the cycle after the 8th command bit, with no identity bits exchanged.
- R8: In a search, identity bit i (from 0 upward) takes three slots. The first read slot returns `rom_id[i]`. The second returns its complement. The next written bit is the master's choice. When the choice equals `rom_id[i]`, the block moves to bit i+1. After bit 63 it raises `func_grant`.
- R9: In a search, a written choice that differs from the slave's own bit makes the block dormant until the next bus reset, with `tx_bit` held at 1.
- R10: For 0xEC, `alarm_active` is sampled in the cycle that completes the command byte. If it is 1 the block behaves as for 0xF0. If it is 0 the block goes dormant.
- R11: Any command byte other than the five codes makes the block dormant until the next bus reset, with the bus released.
- R12: `tx_bit` is 0 only while an identity bit or its search complement is being offered. In every other state it reads 1.
- R13: A strobe that does not fit the current step is ignored. Examples: a written bit during readout, or a read slot while a search awaits the master's choice. Such a strobe changes neither the bit position nor the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low block reset, sampled on clk |
| bus_reset_stb | input | 1 | One-cycle strobe: bus reset detected |
| rx_stb | input | 1 | One-cycle strobe: master wrote a bit |
| rx_bit | input | 1 | Value of the written bit, valid with rx_stb |
| rd_req_stb | input | 1 | One-cycle strobe: master opened a read slot; tx_bit is used in this cycle |
| rom_id | input | 64 | Slave identity: check byte, serial, family code (family in bits 7:0) |
| alarm_active | input | 1 | Last measurement outside the trigger window |
| tx_bit | output | 1 | Level to drive in the read slot: 0 pull low, 1 release |
| func_grant | output | 1 | Memory-function layer may be accessed |

## Verification
A bus reset strobe can land in the same cycle as a written-bit strobe, for example while the last command bit or the last compare bit arrives. The bench drives both strobes together, then sends a full 0xCC byte. It requires the grant to appear only after exactly eight more bits, which shows that the coinciding bit was dropped and the reset took priority. A reset strobe is also driven while the grant is already high. The grant must fall in the very next cycle.

// File: rtl/owire_rom_layer.sv
module owire_rom_layer #(
  parameter int ROM_W = 64,
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] OP_READ  = 8'h33,
  parameter logic [CMD_W-1:0] OP_MATCH = 8'h55,
  parameter logic [CMD_W-1:0] OP_SKIP  = 8'hCC,
  parameter logic [CMD_W-1:0] OP_SRCH  = 8'hF0,
  parameter logic [CMD_W-1:0] OP_ALARM = 8'hEC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset_stb,
  input  logic             rx_stb,
  input  logic             rx_bit,
  input  logic             rd_req_stb,
  input  logic [ROM_W-1:0] rom_id,
  input  logic             alarm_active,
  output logic             tx_bit,
  output logic             func_grant
);
  localparam int IW = $clog2(ROM_W);
  localparam int CW = $clog2(CMD_W);

  localparam logic [2:0] S_DORM  = 3'd0;
  localparam logic [2:0] S_CMD   = 3'd1;
  localparam logic [2:0] S_READ  = 3'd2;
  localparam logic [2:0] S_MATCH = 3'd3;
  localparam logic [2:0] S_SRCH  = 3'd4;
  localparam logic [2:0] S_GRANT = 3'd5;

  localparam logic [1:0] P_TRUE = 2'd0;
  localparam logic [1:0] P_COMP = 2'd1;
  localparam logic [1:0] P_PICK = 2'd2;

  logic [2:0]       state;
  logic [1:0]       phase;
  logic [IW-1:0]    idx;
  logic [CW-1:0]    cbit;
  logic [CMD_W-1:0] cmd_sr;
  logic [CMD_W-1:0] cmd_next;
  logic [2:0]       cmd_state;
  logic             own_bit;
  logic             last_bit;

  assign cmd_next = {rx_bit, cmd_sr[CMD_W-1:1]};
  assign own_bit  = rom_id[idx];
  assign last_bit = (idx == IW'(ROM_W - 1));

  always_comb begin
    if (cmd_next == OP_READ)       cmd_state = S_READ;
    else if (cmd_next == OP_MATCH) cmd_state = S_MATCH;
    else if (cmd_next == OP_SKIP)  cmd_state = S_GRANT;
    else if (cmd_next == OP_SRCH)  cmd_state = S_SRCH;
    else if (cmd_next == OP_ALARM) cmd_state = alarm_active ? S_SRCH : S_DORM;
    else                           cmd_state = S_DORM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_DORM;
      phase  <= P_TRUE;
      idx    <= '0;
      cbit   <= '0;
      cmd_sr <= '0;
    end else if (bus_reset_stb) begin
      state  <= S_CMD;
      phase  <= P_TRUE;
      idx    <= '0;
      cbit   <= '0;
      cmd_sr <= '0;
    end else begin
      case (state)
        S_CMD:
          if (rx_stb) begin
            cmd_sr <= cmd_next;
            cbit   <= cbit + 1'b1;
            if (cbit == CW'(CMD_W - 1)) state <= cmd_state;
          end
        S_READ:
          if (rd_req_stb) begin
            if (last_bit) state <= S_GRANT;
            else          idx   <= idx + 1'b1;
          end
        S_MATCH:
          if (rx_stb) begin
            if (rx_bit != own_bit) state <= S_DORM;
            else if (last_bit)     state <= S_GRANT;
            else                   idx   <= idx + 1'b1;
          end
        S_SRCH:
          case (phase)
            P_TRUE: if (rd_req_stb) phase <= P_COMP;
            P_COMP: if (rd_req_stb) phase <= P_PICK;
            default:
              if (rx_stb) begin
                phase <= P_TRUE;
                if (rx_bit != own_bit) state <= S_DORM;
                else if (last_bit)     state <= S_GRANT;
                else                   idx   <= idx + 1'b1;
              end
          endcase
        default: ;
      endcase
    end
  end

  assign tx_bit = (state == S_READ)                    ? own_bit  :
                  (state == S_SRCH && phase == P_TRUE) ? own_bit  :
                  (state == S_SRCH && phase == P_COMP) ? ~own_bit : 1'b1;
  assign func_grant = (state == S_GRANT);
endmodule

module owire_rom_layer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset_stb,
  input logic       rx_stb,
  input logic       rx_bit,
  input logic       rd_req_stb,
  input logic       tx_bit,
  input logic       func_grant,
  input logic [2:0] st,
  input logic [1:0] ph,
  input logic       own_bit
);
  // R2
  bus_reset_clears_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_stb |=> !func_grant);
  // R12
  pull_low_only_offering_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit |-> (st == 3'd2 || (st == 3'd4 && ph != 2'd2)));
  // R6
  dormant_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !bus_reset_stb) |=> (st == 3'd0 && tx_bit && !func_grant));
  // R8
  grant_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func_grant && !bus_reset_stb) |=> func_grant);
  // R9
  search_dropout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && ph == 2'd2 && rx_stb && rx_bit != own_bit && !bus_reset_stb)
      |=> (tx_bit && !func_grant));
  // R13
  pick_ignores_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && ph == 2'd2 && rd_req_stb && !rx_stb && !bus_reset_stb)
      |=> (st == 3'd4 && ph == 2'd2));
endmodule

bind owire_rom_layer owire_rom_layer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset_stb(bus_reset_stb), .rx_stb(rx_stb),
  .rx_bit(rx_bit), .rd_req_stb(rd_req_stb), .tx_bit(tx_bit),
  .func_grant(func_grant), .st(state), .ph(phase), .own_bit(own_bit)
);

// File: tb/sim_owire_rom_layer.sv
module sim_owire_rom_layer;
  localparam logic [63:0] ROM = 64'h5E00_0008_1A2B_3C28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset_stb = 1'b0, rx_stb = 1'b0, rx_bit = 1'b0, rd_req_stb = 1'b0;
  logic alarm_active = 1'b0;
  logic tx_bit, func_grant;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  owire_rom_layer u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset_stb(bus_reset_stb), .rx_stb(rx_stb),
    .rx_bit(rx_bit), .rd_req_stb(rd_req_stb), .rom_id(ROM),
    .alarm_active(alarm_active), .tx_bit(tx_bit), .func_grant(func_grant)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: mode 0 dormant,1 command,2 readout,3 compare,4 search,5 granted
  int m_mode = 0, m_pos = 0, m_step = 0, m_nb = 0;
  logic [7:0] m_cmd = '0;

  always @(posedge clk) begin
    if (!rst_n) m_mode = 0;
    else if (bus_reset_stb) begin
      m_mode = 1; m_nb = 0; m_pos = 0; m_step = 0;
    end else begin
      case (m_mode)
        1: if (rx_stb) begin
             m_cmd[m_nb] = rx_bit; m_nb++;
             if (m_nb == 8) begin
               case (m_cmd)
                 8'h33: m_mode = 2;
                 8'h55: m_mode = 3;
                 8'hCC: m_mode = 5;
                 8'hF0: m_mode = 4;
                 8'hEC: m_mode = alarm_active ? 4 : 0;
                 default: m_mode = 0;
               endcase
             end
           end
        2: if (rd_req_stb) begin m_pos++; if (m_pos == 64) m_mode = 5; end
        3: if (rx_stb) begin
             if (rx_bit != ROM[m_pos]) m_mode = 0;
             else begin m_pos++; if (m_pos == 64) m_mode = 5; end
           end
        4: if (m_step < 2) begin
             if (rd_req_stb) m_step++;
           end else if (rx_stb) begin
             m_step = 0;
             if (rx_bit != ROM[m_pos]) m_mode = 0;
             else begin m_pos++; if (m_pos == 64) m_mode = 5; end
           end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      logic etx;
      string tag;
      etx = 1'b1;
      if (m_mode == 2) etx = ROM[m_pos];
      if (m_mode == 4 && m_step == 0) etx = ROM[m_pos];
      if (m_mode == 4 && m_step == 1) etx = ~ROM[m_pos];
      case (m_mode)
        0: tag = "R12 model dormant";
        1: tag = "R3 model command";
        2: tag = "R4 model readout";
        3: tag = "R5 model compare";
        4: tag = "R8 model search";
        default: tag = "R7 model granted";
      endcase
      chk(tag, {63'd0, tx_bit}, {63'd0, etx});
      chk(tag, {63'd0, func_grant}, {63'd0, m_mode == 5});
    end
  end

  task automatic bus_reset();
    bus_reset_stb = 1'b1; @(negedge clk); bus_reset_stb = 1'b0;
  endtask
  task automatic wr(input logic b);
    rx_stb = 1'b1; rx_bit = b; @(negedge clk); rx_stb = 1'b0;
  endtask
  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr(v[i]);
  endtask
  task automatic rd(output logic b);
    rd_req_stb = 1'b1; #1 b = tx_bit; @(negedge clk); rd_req_stb = 1'b0;
  endtask

  logic t, c;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 grant after reset", {63'd0, func_grant}, 64'd0);
    chk("R1 tx after reset", {63'd0, tx_bit}, 64'd1);
    wr_byte(8'hCC); #2;
    chk("R1 command ignored before bus reset", {63'd0, func_grant}, 64'd0);
    @(negedge clk);

    // readout, with an ignored written bit in the middle
    bus_reset(); wr_byte(8'h33);
    for (int i = 0; i < 64; i++) begin
      if (i == 20) wr(1'b0);
      rd(t);
      chk(i == 20 ? "R13 readout ignores write" : "R4 readout bit", {63'd0, t}, {63'd0, ROM[i]});
    end
    #2 chk("R4 grant after readout", {63'd0, func_grant}, 64'd1);
    @(negedge clk);
    bus_reset(); #2;
    chk("R2 grant cleared by bus reset", {63'd0, func_grant}, 64'd0);
    @(negedge clk);

    // compare, full match
    bus_reset(); wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr(ROM[i]);
    #2 chk("R5 grant after match", {63'd0, func_grant}, 64'd1);
    @(negedge clk);

    // compare, mismatch at bit 40
    bus_reset(); wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr(i == 40 ? ~ROM[i] : ROM[i]);
    #2 chk("R6 no grant after mismatch", {63'd0, func_grant}, 64'd0);
    @(negedge clk);
    rd(t); chk("R6 released after mismatch", {63'd0, t}, 64'd1);

    // skip
    bus_reset(); wr_byte(8'hCC); #2;
    chk("R7 grant after skip", {63'd0, func_grant}, 64'd1);
    @(negedge clk);

    // full search pass following own bits
    bus_reset(); wr_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rd(t); rd(c);
      chk("R8 search true bit", {63'd0, t}, {63'd0, ROM[i]});
      chk("R8 search complement", {63'd0, c}, {63'd0, ~ROM[i]});
      if (i == 9) begin
        rd(t); chk("R13 read during pick phase", {63'd0, t}, 64'd1);
      end
      wr(ROM[i]);
    end
    #2 chk("R8 grant after search", {63'd0, func_grant}, 64'd1);
    @(negedge clk);

    // search, master picks the other branch at bit 5
    bus_reset(); wr_byte(8'hF0);
    for (int i = 0; i < 6; i++) begin
      rd(t); rd(c); wr(i == 5 ? ~ROM[i] : ROM[i]);
    end
    rd(t); rd(c);
    chk("R9 dropped out true slot", {63'd0, t}, 64'd1);
    chk("R9 dropped out complement slot", {63'd0, c}, 64'd1);

    // alarm search without and with alarm
    bus_reset(); wr_byte(8'hEC);
    rd(t); rd(c);
    chk("R10 no alarm releases true", {63'd0, t}, 64'd1);
    chk("R10 no alarm releases complement", {63'd0, c}, 64'd1);
    alarm_active = 1'b1;
    bus_reset(); wr_byte(8'hEC);
    alarm_active = 1'b0;
    for (int i = 0; i < 64; i++) begin
      rd(t); rd(c);
      chk("R10 alarm search true bit", {63'd0, t}, {63'd0, ROM[i]});
      chk("R10 alarm search complement", {63'd0, c}, {63'd0, ~ROM[i]});
      wr(ROM[i]);
    end
    #2 chk("R10 grant after alarm search", {63'd0, func_grant}, 64'd1);
    @(negedge clk);

    // unknown command
    bus_reset(); wr_byte(8'hA5);
    rd(t); chk("R11 unknown command releases bus", {63'd0, t}, 64'd1);
    #2 chk("R11 unknown command no grant", {63'd0, func_grant}, 64'd0);
    @(negedge clk);

    // bus reset coinciding with a written bit, from the granted state
    bus_reset(); wr_byte(8'hCC);
    bus_reset_stb = 1'b1; rx_stb = 1'b1; rx_bit = 1'b1;
    @(negedge clk);
    bus_reset_stb = 1'b0; rx_stb = 1'b0; #2;
    chk("R2 reset wins over bit strobe", {63'd0, func_grant}, 64'd0);
    @(negedge clk);
    for (int i = 0; i < 7; i++) wr(8'hCC >> i);
    #2 chk("R2 coinciding bit discarded", {63'd0, func_grant}, 64'd0);
    @(negedge clk);
    wr(1'b1); #2;
    chk("R3 grant after eighth bit", {63'd0, func_grant}, 64'd1);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule